// File: doc/BRIEF.md
# Two-Level Stride Audio Sample Address Generator

This block computes the memory word addresses needed to move multichannel 16-bit audio samples between one fixed serial-port data register and a set of per-channel sample buffers. In receive direction the fixed register is the source and samples arriving in interleaved channel order are scattered into contiguous per-channel regions. In transmit direction the fixed register is the destination and samples are gathered from those regions back into interleaved order. Addresses count bytes, so each sample is 2 bytes apart within a channel region.

Each incoming request strobe moves one sample. The indexed address walks with two strides. Inside a frame it jumps by twice the buffer size to reach the same slot of the next channel. After the last channel it steps back to the next slot of channel 0. When a whole block (channels times buffer size samples) is finished, a one-cycle completion pulse with a programmable code is raised. The engine then reloads, with no gap, from the parameter record that the finished record links to. Two records that point at each other give ping-pong buffering.

Parameter records are written through a load port while the engine is idle. A start strobe selects the first record. After that the engine runs until reset.

Top module: `dma_deinterleave_agu`

## Requirements
- R1: After reset, `busy`, `xfer_valid`, `done_irq`, `ovf`, `done_code`, `src_addr` and `dst_addr` are all zero.
- R2: With direction bit 0 (receive), every transfer has `src_addr` equal to `FIXED_ADDR` and the indexed address on `dst_addr`. With direction bit 1 (transmit), the indexed address is on `src_addr` and `dst_addr` equals `FIXED_ADDR`.
- R3: Within a frame, each transfer's indexed address equals the previous one plus 2 × buffer size.
- R4: After the last channel of a frame, the next indexed address is the first address of that frame plus 2. Element c of frame f is therefore at base + 2 × (c × bufsz + f).
- R5: A block is chans × bufsz transfers. Its last transfer is accompanied in the same cycle by a one-cycle `done_irq`, and `done_code` then shows the record's code and holds it until the next completion.
- R6: The transfer after a completion uses the linked record (base, direction, sizes, code, link) at once, and requests still waiting are carried over.
- R7: A request sampled at clock edge k with none waiting gives `xfer_valid` after edge k+1. Transfers are at least two cycles apart, and waiting requests are serviced in arrival order.
- R8: Up to 2 requests can wait. A request that arrives when 2 are waiting and none is issued in that cycle is dropped and sets `ovf`, which stays set until reset.
- R9: While `busy` is high, `load_en` and `start` have no effect. While `busy` is low, `req` has no effect.
- R10: `start` while idle sets `busy` and begins at base address element 0 of record `start_sel`. Chans = 1 and bufsz = 1 complete a block on every transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one parameter record (idle only) |
| load_sel | input | REC_W | Record index to write |
| load_dir | input | 1 | 0 receive, 1 transmit |
| load_base | input | ADDR_W | Byte base address of channel 0 region |
| load_chans | input | CH_W | Channel count (1 or more) |
| load_bufsz | input | BUF_W | Samples per channel region (1 or more) |
| load_code | input | CODE_W | Completion code |
| load_link | input | REC_W | Record to reload after completion |
| start | input | 1 | Begin operation (idle only) |
| start_sel | input | REC_W | First record to run |
| req | input | 1 | One-sample transfer request |
| src_addr | output | ADDR_W | Source byte address of the current transfer |
| dst_addr | output | ADDR_W | Destination byte address of the current transfer |
| xfer_valid | output | 1 | One transfer presented this cycle |
| done_irq | output | 1 | Block completion pulse |
| done_code | output | CODE_W | Code of the last completed block |
| ovf | output | 1 | Sticky request overflow |
| busy | output | 1 | Engine running |

## Verification
A new request strobe and the final transfer of a block can land in the same cycle. In that cycle the waiting-request count, the completion pulse and the reload from the linked record all change together. The bench provokes this with requests spaced so that one arrives on the completing issue edge, and also with back-to-back requests across a block boundary. It judges the result against a behavioural model that computes each address as base + 2 × (channel × bufsz + slot) and follows the link explicitly. Overflow on a saturated queue is pushed in the same way, with requests on every cycle while issues alternate.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
endpackage

// File: rtl/agu_rec_table.sv
module agu_rec_table #(
  parameter int NREC   = 2,
  parameter int REC_W  = 1,
  parameter int ADDR_W = 16,
  parameter int CH_W   = 4,
  parameter int BUF_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [REC_W-1:0]  waddr,
  input  logic              w_dir,
  input  logic [ADDR_W-1:0] w_base,
  input  logic [CH_W-1:0]   w_chans,
  input  logic [BUF_W-1:0]  w_bufsz,
  input  logic [CODE_W-1:0] w_code,
  input  logic [REC_W-1:0]  w_link,
  input  logic [REC_W-1:0]  raddr,
  output logic              r_dir,
  output logic [ADDR_W-1:0] r_base,
  output logic [CH_W-1:0]   r_chans,
  output logic [BUF_W-1:0]  r_bufsz,
  output logic [CODE_W-1:0] r_code,
  output logic [REC_W-1:0]  r_link
);
  // small distributed storage, no reset so it maps to LUT RAM
  logic              dir_m   [NREC];
  logic [ADDR_W-1:0] base_m  [NREC];
  logic [CH_W-1:0]   chans_m [NREC];
  logic [BUF_W-1:0]  bufsz_m [NREC];
  logic [CODE_W-1:0] code_m  [NREC];
  logic [REC_W-1:0]  link_m  [NREC];

  always_ff @(posedge clk) begin
    if (we) begin
      dir_m[waddr]   <= w_dir;
      base_m[waddr]  <= w_base;
      chans_m[waddr] <= w_chans;
      bufsz_m[waddr] <= w_bufsz;
      code_m[waddr]  <= w_code;
      link_m[waddr]  <= w_link;
    end
  end

  assign r_dir   = dir_m[raddr];
  assign r_base  = base_m[raddr];
  assign r_chans = chans_m[raddr];
  assign r_bufsz = bufsz_m[raddr];
  assign r_code  = code_m[raddr];
  assign r_link  = link_m[raddr];
endmodule

// File: rtl/agu_req_queue.sv
module agu_req_queue #(
  parameter int PEND_MAX = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic req,
  input  logic grant,
  output logic has_pend,
  output logic ovf
);
  localparam int CNT_W = $clog2(PEND_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             take;

  always_comb begin
    full = (cnt == CNT_W'(PEND_MAX));
    take = en && req && (!full || grant);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt + CNT_W'(take) - CNT_W'(grant);
      if (en && req && full && !grant) ovf <= 1'b1;
    end
  end

  assign has_pend = (cnt != '0);
endmodule

// File: rtl/agu_addr_walk.sv
module agu_addr_walk
  import agu_pkg::*;
#(
  parameter int REC_W  = 1,
  parameter int ADDR_W = 16,
  parameter int CH_W   = 4,
  parameter int BUF_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  dir_e              r_dir,
  input  logic [ADDR_W-1:0] r_base,
  input  logic [CH_W-1:0]   r_chans,
  input  logic [BUF_W-1:0]  r_bufsz,
  input  logic [CODE_W-1:0] r_code,
  input  logic [REC_W-1:0]  r_link,
  output logic [ADDR_W-1:0] cur_addr,
  output dir_e              cur_dir,
  output logic [CODE_W-1:0] cur_code,
  output logic [REC_W-1:0]  cur_link,
  output logic              blk_end
);
  localparam int PROD_W = BUF_W + CH_W;

  logic [CH_W-1:0]   ecnt, chans_q;
  logic [BUF_W-1:0]  fcnt;
  logic [ADDR_W-1:0] estr, fstr, estr_n, fstr_n;
  logic [PROD_W-1:0] span;

  // strides are computed once per record load, not per step
  always_comb begin
    span   = PROD_W'(r_bufsz) * PROD_W'(r_chans - CH_W'(1));
    estr_n = ADDR_W'({r_bufsz, 1'b0});
    fstr_n = ADDR_W'(2) - ADDR_W'({span, 1'b0});
  end

  assign blk_end = step && (ecnt == CH_W'(1)) && (fcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      ecnt     <= '0;
      chans_q  <= '0;
      fcnt     <= '0;
      estr     <= '0;
      fstr     <= '0;
      cur_dir  <= DIR_RX;
      cur_code <= '0;
      cur_link <= '0;
    end else if (load || blk_end) begin
      cur_addr <= r_base;
      ecnt     <= r_chans;
      chans_q  <= r_chans;
      fcnt     <= r_bufsz - BUF_W'(1);
      estr     <= estr_n;
      fstr     <= fstr_n;
      cur_dir  <= r_dir;
      cur_code <= r_code;
      cur_link <= r_link;
    end else if (step) begin
      if (ecnt != CH_W'(1)) begin
        cur_addr <= cur_addr + estr;
        ecnt     <= ecnt - CH_W'(1);
      end else begin
        cur_addr <= cur_addr + fstr;
        ecnt     <= chans_q;
        fcnt     <= fcnt - BUF_W'(1);
      end
    end
  end
endmodule

// File: rtl/dma_deinterleave_agu.sv
module dma_deinterleave_agu
  import agu_pkg::*;
#(
  parameter int          NREC       = 2,
  parameter int          ADDR_W     = 16,
  parameter int          CH_W       = 4,
  parameter int          BUF_W      = 8,
  parameter int          CODE_W     = 4,
  parameter int          PEND_MAX   = 2,
  parameter logic [15:0] FIXED_ADDR = 16'hF000,
  localparam int         REC_W      = (NREC > 1) ? $clog2(NREC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [REC_W-1:0]  load_sel,
  input  logic              load_dir,
  input  logic [ADDR_W-1:0] load_base,
  input  logic [CH_W-1:0]   load_chans,
  input  logic [BUF_W-1:0]  load_bufsz,
  input  logic [CODE_W-1:0] load_code,
  input  logic [REC_W-1:0]  load_link,
  input  logic              start,
  input  logic [REC_W-1:0]  start_sel,
  input  logic              req,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              xfer_valid,
  output logic              done_irq,
  output logic [CODE_W-1:0] done_code,
  output logic              ovf,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] FIX = ADDR_W'(FIXED_ADDR);

  logic              busy_q, cool_q, issue, has_pend, go, blk_end;
  logic [REC_W-1:0]  rd_sel, cur_link;
  logic              t_dir;
  logic [ADDR_W-1:0] t_base, cur_addr;
  logic [CH_W-1:0]   t_chans;
  logic [BUF_W-1:0]  t_bufsz;
  logic [CODE_W-1:0] t_code, cur_code;
  logic [REC_W-1:0]  t_link;
  dir_e              cur_dir;

  assign go     = start && !busy_q;
  assign rd_sel = busy_q ? cur_link : start_sel;
  assign issue  = busy_q && has_pend && !cool_q;

  agu_rec_table #(
    .NREC(NREC), .REC_W(REC_W), .ADDR_W(ADDR_W),
    .CH_W(CH_W), .BUF_W(BUF_W), .CODE_W(CODE_W)
  ) u_table (
    .clk(clk), .we(load_en && !busy_q), .waddr(load_sel),
    .w_dir(load_dir), .w_base(load_base), .w_chans(load_chans),
    .w_bufsz(load_bufsz), .w_code(load_code), .w_link(load_link),
    .raddr(rd_sel), .r_dir(t_dir), .r_base(t_base), .r_chans(t_chans),
    .r_bufsz(t_bufsz), .r_code(t_code), .r_link(t_link)
  );

  agu_req_queue #(.PEND_MAX(PEND_MAX)) u_queue (
    .clk(clk), .rst(rst), .en(busy_q), .req(req), .grant(issue),
    .has_pend(has_pend), .ovf(ovf)
  );

  agu_addr_walk #(
    .REC_W(REC_W), .ADDR_W(ADDR_W), .CH_W(CH_W),
    .BUF_W(BUF_W), .CODE_W(CODE_W)
  ) u_walk (
    .clk(clk), .rst(rst), .load(go), .step(issue),
    .r_dir(dir_e'(t_dir)), .r_base(t_base), .r_chans(t_chans),
    .r_bufsz(t_bufsz), .r_code(t_code), .r_link(t_link),
    .cur_addr(cur_addr), .cur_dir(cur_dir), .cur_code(cur_code),
    .cur_link(cur_link), .blk_end(blk_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      cool_q     <= 1'b0;
      xfer_valid <= 1'b0;
      done_irq   <= 1'b0;
      done_code  <= '0;
      src_addr   <= '0;
      dst_addr   <= '0;
    end else begin
      if (go) busy_q <= 1'b1;
      cool_q     <= issue;
      xfer_valid <= issue;
      done_irq   <= blk_end;
      if (blk_end) done_code <= cur_code;
      if (issue) begin
        src_addr <= (cur_dir == DIR_TX) ? cur_addr : FIX;
        dst_addr <= (cur_dir == DIR_RX) ? cur_addr : FIX;
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] FIXED_ADDR = 16'hF000
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              busy,
  input logic              xfer_valid,
  input logic              done_irq,
  input logic              ovf,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr
);
  localparam logic [ADDR_W-1:0] FIX = ADDR_W'(FIXED_ADDR);

  assert_xfer_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |=> !xfer_valid);

  assert_irq_on_xfer_R5: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> xfer_valid);

  assert_fixed_side_R2: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> (src_addr == FIX || dst_addr == FIX));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(req));

  assert_xfer_needs_busy_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> busy);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> busy);
endmodule

bind dma_deinterleave_agu agu_checker #(
  .ADDR_W(ADDR_W), .FIXED_ADDR(FIXED_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .busy(busy), .xfer_valid(xfer_valid),
  .done_irq(done_irq), .ovf(ovf), .src_addr(src_addr), .dst_addr(dst_addr)
);

// File: tb/dma_deinterleave_agu_tb.sv
module dma_deinterleave_agu_tb;
  localparam int FIX = 16'hF000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0, load_sel = 1'b0, load_dir = 1'b0;
  logic [15:0] load_base = '0;
  logic [3:0]  load_chans = '0;
  logic [7:0]  load_bufsz = '0;
  logic [3:0]  load_code = '0;
  logic        load_link = 1'b0;
  logic        start = 1'b0, start_sel = 1'b0, req = 1'b0;
  logic [15:0] src_addr, dst_addr;
  logic        xfer_valid, done_irq, ovf, busy;
  logic [3:0]  done_code;

  int checks = 0, failures = 0, cycles = 0;

  always #2 clk = ~clk;

  dma_deinterleave_agu u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
    .load_dir(load_dir), .load_base(load_base), .load_chans(load_chans),
    .load_bufsz(load_bufsz), .load_code(load_code), .load_link(load_link),
    .start(start), .start_sel(start_sel), .req(req),
    .src_addr(src_addr), .dst_addr(dst_addr), .xfer_valid(xfer_valid),
    .done_irq(done_irq), .done_code(done_code), .ovf(ovf), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int r_dir[2], r_base[2], r_ch[2], r_buf[2], r_code[2], r_link[2];
  int m_busy, pend, cool, m_ovf, ch, slot;
  int c_dir, c_base, c_ch, c_buf, c_code, c_link;
  int e_valid, e_irq, e_code, e_src, e_dst;
  bit seen = 0;

  task automatic take_rec(input int s);
    c_dir = r_dir[s]; c_base = r_base[s]; c_ch = r_ch[s];
    c_buf = r_buf[s]; c_code = r_code[s]; c_link = r_link[s];
  endtask

  always @(posedge clk) begin
    int iss, a;
    cycles++;
    seen = 1;
    if (rst) begin
      m_busy = 0; pend = 0; cool = 0; m_ovf = 0; ch = 0; slot = 0;
      e_valid = 0; e_irq = 0; e_code = 0; e_src = 0; e_dst = 0;
    end else begin
      iss = (m_busy != 0 && pend > 0 && cool == 0) ? 1 : 0;
      e_valid = iss; e_irq = 0;
      if (m_busy != 0 && req) begin
        if (pend == 2 && iss == 0) m_ovf = 1; else pend++;
      end
      if (iss != 0) begin
        pend--;
        a = (c_base + 2 * (ch * c_buf + slot)) & 16'hFFFF;
        if (c_dir != 0) begin e_src = a; e_dst = FIX; end
        else begin e_src = FIX; e_dst = a; end
        ch++;
        if (ch == c_ch) begin
          ch = 0; slot++;
          if (slot == c_buf) begin
            slot = 0; e_irq = 1; e_code = c_code; take_rec(c_link);
          end
        end
      end
      cool = iss;
      if (m_busy == 0 && load_en) begin
        r_dir[load_sel] = load_dir; r_base[load_sel] = load_base;
        r_ch[load_sel] = load_chans; r_buf[load_sel] = load_bufsz;
        r_code[load_sel] = load_code; r_link[load_sel] = load_link;
      end
      if (m_busy == 0 && start) begin
        m_busy = 1; take_rec(start_sel); ch = 0; slot = 0;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  logic [15:0] obs_src[$], obs_dst[$];
  int          obs_irq[$], obs_code[$];
  always @(negedge clk) begin
    if (seen) begin
      chk(xfer_valid == e_valid[0], "R7 xfer_valid", xfer_valid, e_valid);
      chk(src_addr == e_src[15:0], "R2 src_addr", src_addr, e_src);
      chk(dst_addr == e_dst[15:0], "R2 dst_addr", dst_addr, e_dst);
      chk(done_irq == e_irq[0], "R5 done_irq", done_irq, e_irq);
      chk(done_code == e_code[3:0], "R5 done_code", done_code, e_code);
      chk(ovf == m_ovf[0], "R8 ovf", ovf, m_ovf);
      chk(busy == m_busy[0], "R10 busy", busy, m_busy);
      if (xfer_valid) begin
        obs_src.push_back(src_addr); obs_dst.push_back(dst_addr);
        obs_irq.push_back(int'(done_irq)); obs_code.push_back(int'(done_code));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(2); rst = 1'b0; tick(1);
    obs_src.delete(); obs_dst.delete(); obs_irq.delete(); obs_code.delete();
  endtask

  task automatic load_rec(input bit sel, input bit dir, input int base,
                          input int chans, input int bsz, input int code, input bit lnk);
    load_en = 1'b1; load_sel = sel; load_dir = dir; load_base = 16'(base);
    load_chans = 4'(chans); load_bufsz = 8'(bsz); load_code = 4'(code); load_link = lnk;
    tick(1);
    load_en = 1'b0;
  endtask

  task automatic go(input bit sel);
    start = 1'b1; start_sel = sel; tick(1); start = 1'b0;
  endtask

  task automatic reqs(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      req = 1'b1; tick(1); req = 1'b0; tick(gap);
    end
  endtask

  initial begin
    // R1: reset state
    do_reset();
    chk(busy == 0 && xfer_valid == 0 && done_irq == 0 && ovf == 0, "R1 flags", {busy, xfer_valid, done_irq, ovf}, 0);
    chk(src_addr == 0 && dst_addr == 0 && done_code == 0, "R1 addrs", src_addr | dst_addr, 0);

    // Scenario A: rx record 0 linked to tx record 1
    load_rec(0, 0, 'h100, 3, 4, 5, 1);
    load_rec(1, 1, 'h200, 2, 3, 9, 0);
    reqs(2, 2);                       // R9: requests while idle are ignored
    chk(obs_src.size() == 0, "R9 idle req", obs_src.size(), 0);
    go(0);
    load_rec(1, 1, 'h300, 2, 3, 9, 0); // R9: ignored while busy
    go(1);                             // R9: ignored while busy
    // R7 latency: accepted at next edge, valid after the following one
    req = 1'b1; tick(1); req = 1'b0;
    chk(xfer_valid == 0, "R7 latency early", xfer_valid, 0);
    tick(1);
    chk(xfer_valid == 1, "R7 latency", xfer_valid, 1);
    reqs(19, 2);
    tick(4);
    chk(obs_dst.size() == 20, "R7 count", obs_dst.size(), 20);
    chk(obs_src[0] == FIX && obs_dst[0] == 'h100, "R2 rx first/R10 base", obs_dst[0], 'h100);
    chk(obs_dst[1] == 'h108, "R3 elem stride", obs_dst[1], 'h108);
    chk(obs_dst[2] == 'h110, "R3 elem stride 2", obs_dst[2], 'h110);
    chk(obs_dst[3] == 'h102, "R4 frame stride", obs_dst[3], 'h102);
    chk(obs_dst[11] == 'h116 && obs_irq[11] == 1, "R5 last of block", obs_dst[11], 'h116);
    chk(obs_code[11] == 5, "R5 code", obs_code[11], 5);
    chk(obs_irq[10] == 0, "R5 no early irq", obs_irq[10], 0);
    chk(obs_src[12] == 'h200 && obs_dst[12] == FIX, "R6 R2 R9 linked tx", obs_src[12], 'h200);
    chk(obs_src[13] == 'h206, "R3 tx stride", obs_src[13], 'h206);
    chk(obs_src[14] == 'h202, "R4 tx frame stride", obs_src[14], 'h202);
    chk(obs_irq[17] == 1 && obs_code[17] == 9, "R5 second block", obs_code[17], 9);
    chk(obs_dst[18] == 'h100, "R6 ping-pong back", obs_dst[18], 'h100);

    // Scenario B: back-to-back requests saturate the queue across a boundary
    do_reset();
    load_rec(0, 0, 'h40, 2, 2, 3, 0);
    go(0);
    chk(ovf == 0, "R8 no ovf yet", ovf, 0);
    req = 1'b1; tick(8); req = 1'b0;
    tick(10);
    chk(ovf == 1, "R8 overflow set", ovf, 1);
    chk(obs_dst[4] == 'h40 && obs_irq[3] == 1, "R6 R8 carry over boundary", obs_dst[4], 'h40);
    go(0);
    tick(2);
    chk(ovf == 1, "R8 sticky", ovf, 1);

    // Scenario C: one channel, one slot, started from record 1
    do_reset();
    load_rec(1, 1, 'h80, 1, 1, 7, 1);
    go(1);
    reqs(3, 3);
    tick(4);
    chk(obs_src.size() == 3, "R10 count", obs_src.size(), 3);
    for (int i = 0; i < 3; i++) begin
      chk(obs_src[i] == 'h80 && obs_irq[i] == 1 && obs_code[i] == 7, "R10 R5 single", obs_src[i], 'h80);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule